// File: doc/BRIEF.md
# Programmable Smart Card Clock Generator

This block produces the clock that drives an ISO 7816 smart card. It takes two free-running source clocks, a crystal clock and a PLL clock, and picks one of them from a select bit and an external-48 strap. The chosen clock is divided by an even ratio set by a 6-bit reload value N. A value of N = 48 passes the source clock through undivided.

The reload value is held in an 8-bit control register. The register is written and read back in the crystal clock domain, and out-of-range writes are clamped. The divider is a down-counter in the selected-source domain. A new reload value takes effect only at a half-period boundary, and a change of source goes through a glitch-free handshake multiplexer. Because of this, the card never sees a shortened high or low phase when software reprograms the clock.

Top module: `card_clk_gen`

## Requirements
- R1: While the reload value N is below 48, `card_clk` has a period of 2×(48−N) cycles of the selected source clock, and its high and low phases are equal.
- R2: While N equals 48, `card_clk` follows the selected source clock undivided.
- R3: A write (`wr_en` high at a rising edge of `clk_xtal`) stores `wr_data[5:0]` as the reload value, and the value reads back on `rd_data[5:0]` from the next cycle. Written values from 49 to 63 are stored as 48, so the output runs in bypass.
- R4: After reset the reload value is 47, which gives divide-by-two. `rd_data[7:6]` always read as 0, and `wr_data[7:6]` have no effect.
- R5: The crystal clock is the source when `src_sel` is 1, or when `src_sel` is 0 and `ext48_strap` is 1. The PLL clock is the source only when both are 0.
- R6: When the source changes, the two source clocks are never enabled at the same time. No phase of `card_clk` is shorter than the shorter of the two sources' divided half-periods.
- R7: A reload value written partway through an output phase does not change that phase's length. The new ratio applies from the next half-period boundary.
- R8: When the block enters or leaves bypass, no phase of `card_clk` is shorter than half a source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal source clock; it also clocks the register port |
| clk_pll | input | 1 | PLL source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source select; 1 forces the crystal clock |
| ext48_strap | input | 1 | External-48 strap; 1 also selects the crystal clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data; bits 5:0 are the reload value |
| rd_data | output | 8 | Register read-back; bits 7:6 are zero |
| card_clk | output | 1 | Clock to the card |

## Verification
The hardest conditions to reach from the ports are a register write or a source change that lands in the middle of an output phase. A flawed design shows its error only as one short or stretched pulse at that moment. To reach this, the bench programs the largest ratio and waits for a card clock edge. It then writes a new value well inside the 480 ns phase and times that exact phase and the one after it. For source changes and for moves into and out of bypass, a monitor runs through the whole transition and records the narrowest high or low phase. That minimum is then compared against the shortest legal half-period.

// File: rtl/ckgen_pkg.sv
`timescale 1ns/1ps
package ckgen_pkg;
  localparam int unsigned CKG_RELOAD_W = 6;   // reload field width
  localparam int unsigned CKG_REG_W    = 8;   // register width on the port
  localparam int unsigned CKG_BYPASS   = 48;  // reload code that bypasses the divider
  localparam int unsigned CKG_RESET    = 47;  // reset code, divide-by-two
  localparam int unsigned CKG_SYNC     = 2;   // synchronizer depth

  typedef enum logic {SRC_XTAL = 1'b0, SRC_PLL = 1'b1} ckgen_src_e;
endpackage

// File: rtl/ckgen_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module ckgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/ckgen_switch_leg.sv
`timescale 1ns/1ps
// One side of the glitch-free source multiplexer. The request is
// synchronized on the rising edge. The enable changes on the falling
// edge, while this leg's clock is low.
module ckgen_switch_leg #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_en,
  output logic en
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              en_q;
  logic              en_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], want & ~other_en};
    en_d   = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/ckgen_clk_switch.sv
`timescale 1ns/1ps
module ckgen_clk_switch
  import ckgen_pkg::*;
#(
  parameter int unsigned STAGES = CKG_SYNC
) (
  input  logic clk_xtal,
  input  logic clk_pll,
  input  logic rst_x_n,
  input  logic rst_p_n,
  input  logic use_xtal,
  output logic clk_src,
  output logic en_xtal,
  output logic en_pll
);
  ckgen_src_e want_src;

  always_comb begin
    want_src = use_xtal ? SRC_XTAL : SRC_PLL;
  end

  ckgen_switch_leg #(.STAGES(STAGES)) u_leg_xtal (
    .clk      (clk_xtal),
    .rst_n    (rst_x_n),
    .want     (want_src == SRC_XTAL),
    .other_en (en_pll),
    .en       (en_xtal)
  );

  ckgen_switch_leg #(.STAGES(STAGES)) u_leg_pll (
    .clk      (clk_pll),
    .rst_n    (rst_p_n),
    .want     (want_src == SRC_PLL),
    .other_en (en_xtal),
    .en       (en_pll)
  );

  assign clk_src = (clk_xtal & en_xtal) | (clk_pll & en_pll);
endmodule

// File: rtl/ckgen_divider.sv
`timescale 1ns/1ps
// Down-counter divider. The output toggles every (BYPASS-N) source
// cycles. A new N is taken only when a phase ends. Bypass is entered and
// left through a falling-edge enable, so the change happens while both
// paths are low.
module ckgen_divider #(
  parameter int unsigned RELOAD_W   = 6,
  parameter int unsigned BYPASS_VAL = 48
) (
  input  logic                clk_src,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload,
  output logic                card_clk,
  output logic [RELOAD_W-1:0] cnt_o,
  output logic                div_o,
  output logic                byp_en_o
);
  localparam logic [RELOAD_W-1:0] BYP_CODE = RELOAD_W'(BYPASS_VAL);
  localparam logic [RELOAD_W-1:0] ONE      = RELOAD_W'(1);

  logic [RELOAD_W-1:0] cnt_q, cnt_d;
  logic                div_q, div_d;
  logic                breq_q, breq_d;
  logic                byp_en_q, byp_en_d;
  logic                go_byp;
  logic [RELOAD_W-1:0] half_new;

  always_comb begin
    go_byp   = (reload >= BYP_CODE);
    half_new = go_byp ? ONE : (BYP_CODE - reload);
  end

  always_comb begin
    cnt_d  = cnt_q;
    div_d  = div_q;
    breq_d = breq_q;
    if (breq_q) begin
      if (!go_byp) begin
        breq_d = 1'b0;
        cnt_d  = half_new;
      end
    end else if (cnt_q == ONE) begin
      cnt_d = half_new;
      div_d = ~div_q;
      if (go_byp && div_q) breq_d = 1'b1;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ONE;
      div_q  <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      breq_q <= breq_d;
    end
  end

  always_comb begin
    byp_en_d = div_q ? byp_en_q : breq_q;
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) byp_en_q <= 1'b0;
    else        byp_en_q <= byp_en_d;
  end

  assign card_clk = byp_en_q ? clk_src : div_q;
  assign cnt_o    = cnt_q;
  assign div_o    = div_q;
  assign byp_en_o = byp_en_q;
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
  import ckgen_pkg::*;
#(
  parameter int unsigned RELOAD_W    = CKG_RELOAD_W,
  parameter int unsigned REG_W       = CKG_REG_W,
  parameter int unsigned BYPASS_VAL  = CKG_BYPASS,
  parameter int unsigned RESET_VAL   = CKG_RESET,
  parameter int unsigned SYNC_STAGES = CKG_SYNC
) (
  input  logic             clk_xtal,
  input  logic             clk_pll,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             ext48_strap,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             card_clk
);
  localparam int unsigned          PAD_W    = REG_W - RELOAD_W;
  localparam logic [RELOAD_W-1:0] BYP_CODE = RELOAD_W'(BYPASS_VAL);
  localparam logic [RELOAD_W-1:0] RST_CODE = RELOAD_W'(RESET_VAL);

  logic                rst_x_n, rst_p_n, rst_src_n;
  logic                clk_src, en_xtal, en_pll;
  logic                use_xtal;
  logic [RELOAD_W-1:0] reload_q, reload_d, wr_field;
  logic [RELOAD_W-1:0] div_cnt;
  logic                div_out, byp_en;

  ckgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_xtal (
    .clk(clk_xtal), .rst_n_in(rst_n), .rst_n_out(rst_x_n));
  ckgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_pll (
    .clk(clk_pll), .rst_n_in(rst_n), .rst_n_out(rst_p_n));
  ckgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_src (
    .clk(clk_src), .rst_n_in(rst_n), .rst_n_out(rst_src_n));

  // Register next state: illegal codes clamp to bypass.
  always_comb begin
    wr_field = wr_data[RELOAD_W-1:0];
    reload_d = reload_q;
    if (wr_en) reload_d = (wr_field > BYP_CODE) ? BYP_CODE : wr_field;
  end

  always_ff @(posedge clk_xtal or negedge rst_x_n) begin
    if (!rst_x_n) reload_q <= RST_CODE;
    else          reload_q <= reload_d;
  end

  assign rd_data  = {{PAD_W{1'b0}}, reload_q};
  assign use_xtal = src_sel | ext48_strap;

  ckgen_clk_switch #(.STAGES(SYNC_STAGES)) u_switch (
    .clk_xtal (clk_xtal),
    .clk_pll  (clk_pll),
    .rst_x_n  (rst_x_n),
    .rst_p_n  (rst_p_n),
    .use_xtal (use_xtal),
    .clk_src  (clk_src),
    .en_xtal  (en_xtal),
    .en_pll   (en_pll)
  );

  ckgen_divider #(.RELOAD_W(RELOAD_W), .BYPASS_VAL(BYPASS_VAL)) u_div (
    .clk_src  (clk_src),
    .rst_n    (rst_src_n),
    .reload   (reload_q),
    .card_clk (card_clk),
    .cnt_o    (div_cnt),
    .div_o    (div_out),
    .byp_en_o (byp_en)
  );
endmodule

// File: rtl/card_clk_gen_chk.sv
`timescale 1ns/1ps
module card_clk_gen_chk #(
  parameter int unsigned RELOAD_W   = 6,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned BYPASS_VAL = 48
) (
  input logic                clk_xtal,
  input logic                clk_src,
  input logic                rst_x_n,
  input logic                rst_src_n,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic [REG_W-1:0]    rd_data,
  input logic                en_xtal,
  input logic                en_pll,
  input logic [RELOAD_W-1:0] div_cnt,
  input logic                div_out,
  input logic                byp_en
);
  // R4: the upper register bits always read as zero
  a_r4_reserved_zero: assert property (@(posedge clk_xtal) disable iff (!rst_x_n)
    rd_data[REG_W-1:RELOAD_W] == '0);

  // R3: the stored reload value never exceeds the bypass code
  a_r3_readback_legal: assert property (@(posedge clk_xtal) disable iff (!rst_x_n)
    int'(rd_data[RELOAD_W-1:0]) <= int'(BYPASS_VAL));

  // R3: a write shows up on the read-back port one cycle later, clamped
  a_r3_write_clamp: assert property (@(posedge clk_xtal) disable iff (!rst_x_n)
    wr_en |=> int'(rd_data[RELOAD_W-1:0]) ==
      ((int'($past(wr_data[RELOAD_W-1:0])) > int'(BYPASS_VAL)) ?
        int'(BYPASS_VAL) : int'($past(wr_data[RELOAD_W-1:0]))));

  // R6: the two source legs are never enabled together
  a_r6_one_source: assert property (@(posedge clk_xtal) disable iff (!rst_x_n)
    $onehot0({en_xtal, en_pll}));

  // R1 / R7: the divided output changes only at the end of a count
  a_r7_hold_between: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    (div_cnt != RELOAD_W'(1)) |=> $stable(div_out));

  // R1: the counter stays within one half-period of the largest ratio
  a_r1_count_range: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    (div_cnt != '0) && (int'(div_cnt) <= int'(BYPASS_VAL)));

  // R8: while bypass is enabled, the divided path is parked low
  a_r8_bypass_div_idle: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    byp_en |-> !div_out);
endmodule

bind card_clk_gen card_clk_gen_chk #(
  .RELOAD_W(RELOAD_W), .REG_W(REG_W), .BYPASS_VAL(BYPASS_VAL)
) u_chk (
  .clk_xtal  (clk_xtal),
  .clk_src   (clk_src),
  .rst_x_n   (rst_x_n),
  .rst_src_n (rst_src_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .en_xtal   (en_xtal),
  .en_pll    (en_pll),
  .div_cnt   (div_cnt),
  .div_out   (div_out),
  .byp_en    (byp_en)
);

// File: tb/card_clk_gen_tb.sv
`timescale 1ns/1ps
module card_clk_gen_tb;
  localparam realtime CLK_PERIOD = 10.0;
  localparam realtime PLL_PERIOD = 6.0;

  logic       clk_xtal = 1'b0;
  logic       clk_pll  = 1'b0;
  logic       rst_n;
  logic       src_sel;
  logic       ext48_strap;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       card_clk;

  int checks   = 0;
  int failures = 0;

  realtime last_t, min_w;
  bit      mon, skip;

  always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;
  always #(PLL_PERIOD/2) clk_pll  = ~clk_pll;

  card_clk_gen u_dut (
    .clk_xtal    (clk_xtal),
    .clk_pll     (clk_pll),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .ext48_strap (ext48_strap),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .card_clk    (card_clk)
  );

  // Pulse-width monitor: records the narrowest phase while enabled.
  always @(card_clk) begin
    if (mon) begin
      if (skip) skip = 1'b0;
      else if ($realtime - last_t < min_w) min_w = $realtime - last_t;
    end
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_t(input string req, input string what, input realtime act,
                       input realtime exp);
    real d;
    d = act - exp;
    if (d < 0) d = -d;
    chk(d < 0.01, req, what, act, exp);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk_xtal);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk_xtal);
    wr_en   = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge card_clk);
  endtask

  task automatic measure(output realtime per, output realtime hi);
    realtime t0, t1, t2;
    @(posedge card_clk); t0 = $realtime;
    @(negedge card_clk); t1 = $realtime;
    @(posedge card_clk); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic mon_start();
    min_w = 1.0e9;
    skip  = 1'b1;
    mon   = 1'b1;
  endtask

  task automatic t_reset();
    realtime p, h;
    chk(rd_data == 8'h2F, "R4", "reset read-back", real'(rd_data), 47.0);
    settle();
    measure(p, h);
    chk_t("R4", "reset divide-by-two period", p, 2*CLK_PERIOD);
    chk_t("R4", "reset divide-by-two high", h, CLK_PERIOD);
  endtask

  task automatic t_divide();
    realtime p, h;
    write_reg(8'd40);
    chk(rd_data == 8'd40, "R3", "read-back 40", real'(rd_data), 40.0);
    settle();
    measure(p, h);
    chk_t("R1", "N=40 period", p, 16*CLK_PERIOD);
    chk_t("R1", "N=40 high phase", h, 8*CLK_PERIOD);
    write_reg(8'd0);
    settle();
    measure(p, h);
    chk_t("R1", "N=0 period", p, 96*CLK_PERIOD);
    chk_t("R1", "N=0 high phase", h, 48*CLK_PERIOD);
    write_reg(8'hC5); // upper bits set, field 5
    chk(rd_data == 8'd5, "R4", "upper write bits dropped", real'(rd_data), 5.0);
    settle();
    measure(p, h);
    chk_t("R1", "N=5 period", p, 86*CLK_PERIOD);
  endtask

  task automatic t_bypass();
    realtime p, h;
    write_reg(8'd48);
    settle();
    measure(p, h);
    chk_t("R2", "bypass period", p, CLK_PERIOD);
    chk_t("R2", "bypass high", h, CLK_PERIOD/2);
  endtask

  task automatic t_clamp();
    realtime p, h;
    write_reg(8'd47);
    write_reg(8'd60);
    chk(rd_data == 8'd48, "R3", "write 60 clamps", real'(rd_data), 48.0);
    settle();
    measure(p, h);
    chk_t("R3", "clamped value bypasses", p, CLK_PERIOD);
    write_reg(8'd49);
    chk(rd_data == 8'd48, "R3", "write 49 clamps", real'(rd_data), 48.0);
    write_reg(8'd63);
    chk(rd_data == 8'd48, "R3", "write 63 clamps", real'(rd_data), 48.0);
  endtask

  task automatic set_src(input logic s, input logic x);
    @(negedge clk_xtal);
    src_sel     = s;
    ext48_strap = x;
  endtask

  task automatic t_source();
    realtime p, h;
    write_reg(8'd46);
    set_src(1'b1, 1'b0); settle(); measure(p, h);
    chk_t("R5", "select=1 uses crystal", p, 4*CLK_PERIOD);
    set_src(1'b0, 1'b1); settle(); measure(p, h);
    chk_t("R5", "strap=1 uses crystal", p, 4*CLK_PERIOD);
    set_src(1'b0, 1'b0); settle(); measure(p, h);
    chk_t("R5", "both clear uses PLL", p, 4*PLL_PERIOD);
    chk_t("R5", "PLL high phase", h, 2*PLL_PERIOD);
    set_src(1'b1, 1'b1); settle(); measure(p, h);
    chk_t("R5", "both set uses crystal", p, 4*CLK_PERIOD);
  endtask

  task automatic t_glitch();
    write_reg(8'd47);
    settle();
    mon_start();
    set_src(1'b0, 1'b0); settle();
    set_src(1'b1, 1'b0); settle();
    set_src(1'b0, 1'b0); settle();
    set_src(1'b0, 1'b1); settle();
    mon = 1'b0;
    chk(min_w >= PLL_PERIOD - 0.01, "R6", "narrowest phase over source changes",
        min_w, PLL_PERIOD);
  endtask

  task automatic t_reload_timing();
    realtime t0, t1, t2;
    write_reg(8'd0);
    settle();
    @(posedge card_clk); t0 = $realtime;
    #200;
    write_reg(8'd47);
    @(negedge card_clk); t1 = $realtime;
    @(posedge card_clk); t2 = $realtime;
    chk_t("R7", "phase in progress keeps old length", t1 - t0, 48*CLK_PERIOD);
    chk_t("R7", "next phase uses new length", t2 - t1, CLK_PERIOD);
  endtask

  task automatic t_bypass_transition();
    write_reg(8'd47);
    settle();
    mon_start();
    write_reg(8'd48); settle();
    write_reg(8'd47); settle();
    write_reg(8'd48); settle();
    write_reg(8'd46); settle();
    mon = 1'b0;
    chk(min_w >= CLK_PERIOD/2 - 0.01, "R8", "narrowest phase over bypass changes",
        min_w, CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mon         = 1'b0;
    skip        = 1'b0;
    min_w       = 1.0e9;
    last_t      = 0;
    rst_n       = 1'b0;
    src_sel     = 1'b1;
    ext48_strap = 1'b0;
    wr_en       = 1'b0;
    wr_data     = 8'h00;
    #(CLK_PERIOD*5);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_xtal);
    t_reset();
    t_divide();
    t_bypass();
    t_clamp();
    t_source();
    t_glitch();
    t_reload_timing();
    t_bypass_transition();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule